// File: doc/BRIEF.md
# Reconfigurable Timer/Counter with Capture

This block is a 16-bit counting resource that a two-bit mode field reshapes into either two 8-bit halves or one combined 16-bit count. Each half can advance on ticks from a shared programmable prescaler or on rising edges of an external event input. The external input passes through a two-stage synchroniser before use. Each counter returns to zero when it reaches its match value. On that match it raises a sticky interrupt flag, and software clears the flag by pulsing a clear input. Two capture trigger inputs are also synchronised. On a rising edge, a trigger copies the live count into a capture register, so firmware can timestamp external happenings.

The mode field is decoded into four named operating arrangements, and a unique case picks the step source of each half. `MODE_DUAL_TMR` (code 0) runs two prescaled 8-bit timers. `MODE_TMR_EVT` (code 1) runs a prescaled low timer and an event-counting high half. `MODE_WIDE_TMR` (code 2) runs one prescaled 16-bit timer. `MODE_WIDE_EVT` (code 3) runs one 16-bit event counter. Changing the field moves the block from one arrangement to another on the very next clock. The counts carry over unchanged, and only the stepping and match rules switch.

Top module: `mode_timer_top`

## Requirements
- R1: After reset, both capture registers read 0 and both interrupt flags read 0.
- R2: The prescaler value N yields one tick every N+1 clocks. The first tick falls in the clock cycle that ends the (N+1)-th rising edge after reset, so after K edges floor(K/(N+1)) ticks have occurred.
- R3: In mode code 0, each half adds one per prescaler tick. A half that is at its own match value when a tick arrives goes to 0 instead and sets its own flag (low half: irq_lo, high half: irq_hi). The count after T ticks is therefore T mod (match+1).
- R4: In mode code 1, the low half behaves as in R3. The high half steps once per synchronised rising edge of event_in and wraps at match_hi, setting irq_hi.
- R5: In mode codes 2 and 3, {high, low} form one 16-bit count. It steps on prescaler ticks (code 2) or on event rising edges (code 3) and compares against {match_hi, match_lo}. On a match it goes to 0 and sets irq_hi. In these modes irq_lo never becomes set.
- R6: An event is counted once per rising edge of event_in, however long the input stays high. The count changes at the second rising clock edge after the edge that first samples the input high.
- R7: A rising edge on a capture input loads its capture register with the count held during the cycle in which the synchronised edge appears. That is the count after two more clock edges, before the third edge's update. With no trigger edge, the capture registers hold their values.
- R8: In the 16-bit modes, a cap_lo_in rising edge loads cap_lo_q with the low byte and cap_hi_q with the high byte, and cap_hi_in has no effect.
- R9: Interrupt flags stay set until a one-cycle pulse on the matching clear input removes them. When a set and a clear land in the same cycle, the flag stays set.
- R10: In the 8-bit modes, each capture input loads only its own half's capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Arrangement: 0 dual timer, 1 timer plus event counter, 2 wide timer, 3 wide event counter |
| psc_val | input | 8 | Prescaler terminal value N (divide by N+1) |
| match_lo | input | 8 | Low-half match value (low byte of the wide match) |
| match_hi | input | 8 | High-half match value (high byte of the wide match) |
| event_in | input | 1 | External event input, asynchronous |
| cap_lo_in | input | 1 | Low capture trigger, asynchronous |
| cap_hi_in | input | 1 | High capture trigger, asynchronous |
| clr_lo | input | 1 | Clear pulse for irq_lo |
| clr_hi | input | 1 | Clear pulse for irq_hi |
| cap_lo_q | output | 8 | Low capture register |
| cap_hi_q | output | 8 | High capture register |
| irq_lo | output | 1 | Low-half match flag |
| irq_hi | output | 1 | High-half or wide match flag |

## Verification
The hardest case to reach from the ports is a 16-bit count that has carried into its high byte and also wrapped at a match above 255. The counts are only visible through capture, so the stimulus runs an undivided wide timer for a little over 256 edges and fires a capture to read the carried value. A second capture after the wrap confirms the reload. In event mode, a burst of 258 short pulses reaches the same carry. The exact cycle at which an event lands is pinned down by raising a capture trigger in the same cycle as the event. Because both inputs pass through identical synchronisers, the capture must still show the pre-event count.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    typedef enum logic [1:0] {
        MODE_DUAL_TMR = 2'd0,
        MODE_TMR_EVT  = 2'd1,
        MODE_WIDE_TMR = 2'd2,
        MODE_WIDE_EVT = 2'd3
    } mtc_mode_e;
endpackage

// File: rtl/mtc_sync.sv
module mtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], din};
    end

    assign rise = shreg[STAGES-1] & ~shreg[STAGES];

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + W'(1);
    end

    // R2
    psc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |=> (!tick || !$stable(limit)));
endmodule

// File: rtl/mode_timer_top.sv
module mode_timer_top #(
    parameter int HALF_W      = 8,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [PSC_W-1:0]  psc_val,
    input  logic [HALF_W-1:0] match_lo,
    input  logic [HALF_W-1:0] match_hi,
    input  logic              event_in,
    input  logic              cap_lo_in,
    input  logic              cap_hi_in,
    input  logic              clr_lo,
    input  logic              clr_hi,
    output logic [HALF_W-1:0] cap_lo_q,
    output logic [HALF_W-1:0] cap_hi_q,
    output logic              irq_lo,
    output logic              irq_hi
);
    import mtc_pkg::*;

    localparam int FULL_W = 2 * HALF_W;
    localparam int N_SYNC = 3;

    logic              tick;
    logic [N_SYNC-1:0] async_in;
    logic [N_SYNC-1:0] sync_rise;
    logic              ev_rise, caplo_rise, caphi_rise;

    assign async_in   = {cap_hi_in, cap_lo_in, event_in};
    assign ev_rise    = sync_rise[0];
    assign caplo_rise = sync_rise[1];
    assign caphi_rise = sync_rise[2];

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        mtc_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (async_in[g]),
            .rise (sync_rise[g])
        );
    end

    mtc_prescaler #(.W(PSC_W)) psc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .limit(psc_val),
        .tick (tick)
    );

    // operating arrangement decode
    mtc_mode_e mode_e;
    logic      wide, lo_step, hi_step;

    assign mode_e = mtc_mode_e'(mode);

    always_comb begin
        wide    = 1'b0;
        lo_step = 1'b0;
        hi_step = 1'b0;
        unique case (mode_e)
            MODE_DUAL_TMR: begin lo_step = tick; hi_step = tick;    end
            MODE_TMR_EVT:  begin lo_step = tick; hi_step = ev_rise; end
            MODE_WIDE_TMR: begin wide = 1'b1; lo_step = tick;    end
            MODE_WIDE_EVT: begin wide = 1'b1; lo_step = ev_rise; end
            default:       ;
        endcase
    end

    // counting datapath
    logic [HALF_W-1:0] lo_cnt, hi_cnt, lo_nxt, hi_nxt;
    logic [FULL_W-1:0] full_cnt, full_match;
    logic              set_lo, set_hi;

    assign full_cnt   = {hi_cnt, lo_cnt};
    assign full_match = {match_hi, match_lo};

    always_comb begin
        lo_nxt = lo_cnt;
        hi_nxt = hi_cnt;
        set_lo = 1'b0;
        set_hi = 1'b0;
        if (wide) begin
            if (lo_step) begin
                if (full_cnt == full_match) begin
                    {hi_nxt, lo_nxt} = '0;
                    set_hi           = 1'b1;
                end else begin
                    {hi_nxt, lo_nxt} = full_cnt + FULL_W'(1);
                end
            end
        end else begin
            if (lo_step) begin
                if (lo_cnt == match_lo) begin lo_nxt = '0; set_lo = 1'b1; end
                else                          lo_nxt = lo_cnt + HALF_W'(1);
            end
            if (hi_step) begin
                if (hi_cnt == match_hi) begin hi_nxt = '0; set_hi = 1'b1; end
                else                          hi_nxt = hi_cnt + HALF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            lo_cnt <= lo_nxt;
            hi_cnt <= hi_nxt;
            irq_lo <= set_lo | (irq_lo & ~clr_lo);
            irq_hi <= set_hi | (irq_hi & ~clr_hi);
        end
    end

    // capture registers
    logic hi_trig;
    assign hi_trig = wide ? caplo_rise : caphi_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_lo_q <= '0;
            cap_hi_q <= '0;
        end else begin
            if (caplo_rise) cap_lo_q <= lo_cnt;
            if (hi_trig)    cap_hi_q <= hi_cnt;
        end
    end

    // R9
    irq_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && !clr_lo) |=> irq_lo);

    // R9
    irq_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && !clr_hi) |=> irq_hi);

    // R5
    wide_no_lo_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !irq_lo) |=> !irq_lo);

    // R8
    wide_hi_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && caphi_rise && !caplo_rise) |=> ($stable(cap_lo_q) && $stable(cap_hi_q)));

    // R7
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!caplo_rise && !caphi_rise) |=> ($stable(cap_lo_q) && $stable(cap_hi_q)));
endmodule

// File: tb/mode_timer_top_tb_top.sv
module mode_timer_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic [7:0] psc_val = '0, match_lo = '0, match_hi = '0;
    logic       event_in = 1'b0, cap_lo_in = 1'b0, cap_hi_in = 1'b0;
    logic       clr_lo = 1'b0, clr_hi = 1'b0;
    logic [7:0] cap_lo_q, cap_hi_q;
    logic       irq_lo, irq_hi;

    int checks = 0;
    int errs   = 0;
    int edges  = 0;

    always #2 clk = ~clk;

    mode_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .psc_val(psc_val),
        .match_lo(match_lo), .match_hi(match_hi), .event_in(event_in),
        .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
        .clr_lo(clr_lo), .clr_hi(clr_hi),
        .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int ticks(int k, int n);
        return k / (n + 1);
    endfunction

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic start(int m, int n, int ml, int mh);
        @(negedge clk);
        rst_n = 1'b0;
        mode = 2'(m); psc_val = 8'(n); match_lo = 8'(ml); match_hi = 8'(mh);
        event_in = 0; cap_lo_in = 0; cap_hi_in = 0; clr_lo = 0; clr_hi = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        edges = 0;
    endtask

    // raises triggers now; k = edge count whose result is captured
    task automatic capture(bit lo, bit hi, output int vlo, output int vhi, output int k);
        cap_lo_in = lo;
        cap_hi_in = hi;
        k = edges + 2;
        step(3);
        vlo = int'(cap_lo_q);
        vhi = int'(cap_hi_q);
        cap_lo_in = 0;
        cap_hi_in = 0;
        step(2);
    endtask

    task automatic pulse_events(int count, int high);
        repeat (count) begin
            event_in = 1;
            step(high);
            event_in = 0;
            step(2);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin : main
        int vlo, vhi, k, v, m16, plo;

        // R1 reset state
        start(0, 3, 5, 5);
        chk("R1 cap_lo", cap_lo_q, 0);
        chk("R1 cap_hi", cap_hi_q, 0);
        chk("R1 irq_lo", irq_lo, 0);
        chk("R1 irq_hi", irq_hi, 0);

        // R2 R3 dual 8-bit timers sweep
        for (int n = 0; n < 4; n++) begin
            for (int ml = 0; ml < 5; ml++) begin
                start(0, n, ml, 6);
                step(7 + 3 * n + ml);
                capture(1, 1, vlo, vhi, k);
                chk("R2/R3 lo count", vlo, ticks(k, n) % (ml + 1));
                chk("R3 hi count", vhi, ticks(k, n) % 7);
                chk("R3 irq_lo", irq_lo, int'(ticks(edges, n) >= ml + 1));
                chk("R3 irq_hi", irq_hi, int'(ticks(edges, n) >= 7));
            end
        end

        // R10 independent captures in 8-bit mode
        start(0, 1, 9, 9);
        step(10);
        capture(1, 0, vlo, vhi, k);
        chk("R10 lo captured", vlo, ticks(k, 1) % 10);
        chk("R10 hi untouched", vhi, 0);
        plo = vlo;
        step(5);
        capture(0, 1, vlo, vhi, k);
        chk("R10 hi captured", vhi, ticks(k, 1) % 10);
        chk("R10 lo untouched", vlo, plo);

        // R4 mode 1: prescaled low, event-counted high
        for (int ml = 1; ml < 4; ml++) begin
            start(1, 2, ml, 3);
            pulse_events(5, 1);
            step(4);
            capture(1, 1, vlo, vhi, k);
            chk("R4 hi events", vhi, 5 % 4);
            chk("R4 lo timer", vlo, ticks(k, 2) % (ml + 1));
            chk("R4 irq_hi", irq_hi, 1);
        end

        // R6 long high counts once
        start(1, 0, 200, 9);
        event_in = 1;
        step(20);
        event_in = 0;
        step(4);
        capture(1, 1, vlo, vhi, k);
        chk("R6 long pulse once", vhi, 1);
        chk("R2 undivided lo", vlo, k % 201);

        // R6 R7 event latency equals capture latency
        start(1, 0, 200, 9);
        step(3);
        event_in = 1;
        capture(0, 1, vlo, vhi, k);
        chk("R6/R7 pre-event value captured", vhi, 0);
        event_in = 0;
        step(2);
        capture(0, 1, vlo, vhi, k);
        chk("R6 event counted", vhi, 1);

        // R5 wide timer with carry and wrap above 255
        for (int n = 0; n < 3; n++) begin
            m16 = 260;
            start(2, n, m16 & 255, m16 >> 8);
            step(256 * (n + 1));
            capture(1, 0, vlo, vhi, k);
            v = ticks(k, n) % (m16 + 1);
            chk("R5 wide hi byte", vhi, v >> 8);
            chk("R5 wide lo byte", vlo, v & 255);
            step(40);
            capture(1, 0, vlo, vhi, k);
            v = ticks(k, n) % (m16 + 1);
            chk("R5 wide after more", vhi * 256 + vlo, v);
            chk("R5 irq_hi", irq_hi, int'(ticks(edges, n) >= m16 + 1));
            chk("R5 irq_lo stays 0", irq_lo, 0);
        end

        // R8 high trigger ignored in wide mode
        start(2, 0, 4, 1);
        step(20);
        capture(0, 1, vlo, vhi, k);
        chk("R8 hi trig no lo", vlo, 0);
        chk("R8 hi trig no hi", vhi, 0);
        capture(1, 0, vlo, vhi, k);
        chk("R8 lo trig full", vhi * 256 + vlo, k % 261);

        // R5 R6 wide event counter
        start(3, 0, 4, 0);
        pulse_events(7, 3);
        step(4);
        capture(1, 0, vlo, vhi, k);
        chk("R5 evt wrap lo", vlo, 7 % 5);
        chk("R5 evt wrap hi", vhi, 0);
        chk("R5 evt irq_hi", irq_hi, 1);
        chk("R5 evt irq_lo", irq_lo, 0);

        start(3, 5, 44, 1);
        pulse_events(258, 1);
        step(4);
        capture(1, 0, vlo, vhi, k);
        chk("R5 evt carry hi", vhi, 1);
        chk("R5 evt carry lo", vlo, 2);
        chk("R5 evt no match", irq_hi, 0);

        // R9 sticky flag, clear, set priority
        start(0, 9, 0, 200);
        step(15);
        chk("R9 sticky set", irq_lo, 1);
        clr_lo = 1;
        step(1);
        clr_lo = 0;
        chk("R9 cleared", irq_lo, 0);
        step(4);
        chk("R9 set again", irq_lo, 1);
        clr_lo = 1;
        step(1);
        clr_lo = 0;
        chk("R9 cleared again", irq_lo, 0);
        step(29 - edges);
        clr_lo = 1;
        step(1);
        clr_lo = 0;
        chk("R9 set wins over clear", irq_lo, 1);
        chk("R9 irq_hi untouched", irq_hi, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule